// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration register file of a system controller, reached through two I/O addresses. The host first writes a register number to the index port. It then reads or writes that register through the data port. The file covers a contiguous run of register numbers starting at 20h. A build option adds one more register at the top of the run.

Each data-port access consumes the armed index. Accessing the same register again therefore needs a fresh index write.

On reset the file loads fixed defaults, and one bit of register 25h comes from an external strap input. A read-only revision field is kept constant whatever the host writes. After every accepted data write, a one-cycle change strobe carries the register number out, so that downstream decoders can refresh their own state.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, io_rdata is FFh, chg_valid is low, and the registers hold these values: 20h=40h, 22h=80h, 28h=80h, 29h=10h, 2Ah=80h, 2Bh=10h, 25h as in R6, and every other implemented register 00h.
- R2: A write to I/O address 0022h stores the 8-bit index and arms it. A following write to 0024h stores the data into the selected register. A read of 0024h after a new index write returns the stored value.
- R3: Any read or write at 0024h disarms the index. A data write without an armed index is discarded, and a data read without one returns FFh.
- R4: The implemented indices are 20h to 2Bh, plus 2Ch when HAS_EXTRA=1. For any other index, a data write is discarded and a data read returns FFh.
- R5: Bits 7:6 of register 20h always read as the revision value 01b. Writes to those two bits are discarded, and bits 5:0 of that register are writable.
- R6: At reset, register 25h loads F0h with bit 1 cleared and bit 0 equal to strap_in.
- R7: An accepted data write raises chg_valid for exactly one cycle after the write edge, with chg_index equal to the written index. Discarded writes raise no strobe.
- R8: io_rdata is registered: it takes the read result at the clock edge of a 0024h read strobe and otherwise holds its value, including during reads of other addresses.
- R9: Reads and writes to addresses other than 0022h and 0024h change neither the registers nor the armed index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 1 | Strap level loaded into bit 0 of register 25h at reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| chg_valid | output | 1 | One-cycle register-changed strobe |
| chg_index | output | 8 | Index of the register that changed |

## Verification
The bench builds two copies that share one bus. The first uses HAS_EXTRA=1, so register 2Ch is usable and its writes strobe. The second uses HAS_EXTRA=0, where the same index sits just past the end of the range and has to read FFh with no strobe. Running both under identical stimulus puts the upper range boundary within reach in both variants. Both are built with the default revision and port addresses, which ties the expected revision field and the address decode to fixed values.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_INDEX,
        ACC_DATA_WR,
        ACC_DATA_RD
    } acc_e;

    typedef struct packed {
        logic  armed;
        byte_t idx;
    } sel_t;

    localparam byte_t REV_IDX  = 8'h20;
    localparam byte_t REV_MASK = 8'hC0;
    localparam byte_t NO_DATA  = 8'hFF;

    function automatic byte_t ro_mask(input byte_t idx);
        return (idx == REV_IDX) ? REV_MASK : 8'h00;
    endfunction

    function automatic byte_t ro_bits(input byte_t idx, input logic [1:0] rev);
        return (idx == REV_IDX) ? {rev, 6'b0} : 8'h00;
    endfunction

    function automatic byte_t reset_value(input byte_t idx, input logic strap,
                                          input logic [1:0] rev);
        case (idx)
            8'h20:        return {rev, 6'b0};
            8'h22:        return 8'h80;
            8'h25:        return {6'b111100, 1'b0, strap};
            8'h28, 8'h2A: return 8'h80;
            8'h29, 8'h2B: return 8'h10;
            default:      return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_e              kind
);
    localparam logic [ADDR_W-1:0] IDX_A  = IDX_PORT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DATA_A = DATA_PORT[ADDR_W-1:0];

    always_comb begin
        kind = ACC_NONE;
        if (wr && addr == IDX_A)       kind = ACC_INDEX;
        else if (wr && addr == DATA_A) kind = ACC_DATA_WR;
        else if (rd && addr == DATA_A) kind = ACC_DATA_RD;
    end
endmodule

// File: rtl/cfg_port_sel.sv
module cfg_port_sel
    import cfg_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_e  kind,
    input  byte_t wdata,
    output sel_t  sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '{armed: 1'b0, idx: 8'h00};
        end else begin
            case (kind)
                ACC_INDEX:                sel <= '{armed: 1'b1, idx: wdata};
                ACC_DATA_WR, ACC_DATA_RD: sel.armed <= 1'b0;
                default:                  ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] FIRST = 8'h20,
    parameter int         NREG  = 13,
    parameter logic [1:0] REV   = 2'b01
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strap,
    input  logic  we,
    input  byte_t idx,
    input  byte_t wdata,
    output logic  hit,
    output byte_t rd_val
);
    localparam byte_t NREG_B = 8'(NREG);

    byte_t regs_q [NREG];
    byte_t off;

    assign off = idx - FIRST;
    assign hit = (idx >= FIRST) && (off < NREG_B);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam byte_t MY_IDX = 8'(int'(FIRST) + g);
        localparam byte_t MASK   = ro_mask(MY_IDX);
        localparam byte_t FIXED  = ro_bits(MY_IDX, REV);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= reset_value(MY_IDX, strap, REV);
            else if (we && hit && off == 8'(g))
                regs_q[g] <= (wdata & ~MASK) | (FIXED & MASK);
        end
    end

    always_comb begin
        rd_val = NO_DATA;
        for (int i = 0; i < NREG; i++)
            if (hit && off == 8'(i)) rd_val = regs_q[i];
    end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0024,
    parameter logic [7:0]  FIRST_IDX = 8'h20,
    parameter int          BASE_REGS = 12,
    parameter bit          HAS_EXTRA = 1'b1,
    parameter logic [1:0]  REV_ID    = 2'b01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_in,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    output logic              chg_valid,
    output logic [7:0]        chg_index
);
    localparam int NREG_C = BASE_REGS + (HAS_EXTRA ? 1 : 0);

    acc_e  kind;
    sel_t  sel_q;
    logic  in_range;
    byte_t reg_val;
    logic  commit;
    logic  armed_q;
    byte_t idx_q;

    cfg_port_decode #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
    ) u_dec (
        .addr(io_addr), .wr(io_wr), .rd(io_rd), .kind(kind)
    );

    cfg_port_sel u_sel (
        .clk(clk), .rst(rst), .kind(kind), .wdata(io_wdata), .sel(sel_q)
    );

    assign armed_q = sel_q.armed;
    assign idx_q   = sel_q.idx;
    assign commit  = (kind == ACC_DATA_WR) && armed_q && in_range;

    cfg_port_regs #(
        .FIRST(FIRST_IDX), .NREG(NREG_C), .REV(REV_ID)
    ) u_regs (
        .clk(clk), .rst(rst), .strap(strap_in), .we(commit),
        .idx(idx_q), .wdata(io_wdata), .hit(in_range), .rd_val(reg_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rdata  <= NO_DATA;
            chg_valid <= 1'b0;
            chg_index <= 8'h00;
        end else begin
            if (kind == ACC_DATA_RD)
                io_rdata <= (armed_q && in_range) ? reg_val : NO_DATA;
            chg_valid <= commit;
            if (commit) chg_index <= idx_q;
        end
    end
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] DATA_PORT = 16'h0024,
    parameter logic [7:0]  FIRST     = 8'h20,
    parameter int          NREG      = 13,
    parameter logic [1:0]  REV       = 2'b01
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic              chg_valid,
    input logic [7:0]        chg_index,
    input logic              armed,
    input logic [7:0]        cur_idx
);
    localparam logic [ADDR_W-1:0] DA   = DATA_PORT[ADDR_W-1:0];
    localparam int                LAST = int'(FIRST) + NREG - 1;

    a_r3_disarm: assert property (@(posedge clk) disable iff (rst)
        ((io_wr || io_rd) && io_addr == DA) |=> !armed);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        chg_valid |=> !chg_valid);

    a_r7_from_data_write: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_valid) |-> $past(io_wr && io_addr == DA && armed));

    a_r4_index_in_range: assert property (@(posedge clk) disable iff (rst)
        chg_valid |-> (int'(chg_index) >= int'(FIRST) && int'(chg_index) <= LAST));

    a_r5_revision: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == DA && armed && cur_idx == REV_IDX) |=> io_rdata[7:6] == REV);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_addr == DA) |=> $stable(io_rdata));
endmodule

bind cfg_index_port cfg_index_port_chk #(
    .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .FIRST(FIRST_IDX),
    .NREG(NREG_C), .REV(REV_ID)
) u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .chg_valid(chg_valid), .chg_index(chg_index),
    .armed(armed_q), .cur_idx(idx_q)
);

// File: tb/sim_cfg_index_port.sv
`timescale 1ns/1ps
module sim_cfg_index_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_in = 1'b1;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  rdata0, rdata1, cidx0, cidx1;
    logic        cv0, cv1;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    cfg_index_port #(.HAS_EXTRA(1'b1)) u0 (
        .clk(clk), .rst(rst), .strap_in(strap_in), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(rdata0), .chg_valid(cv0), .chg_index(cidx0));

    cfg_index_port #(.HAS_EXTRA(1'b0)) u1 (
        .clk(clk), .rst(rst), .strap_in(strap_in), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(rdata1), .chg_valid(cv1), .chg_index(cidx1));

    // Vector: {op, req, addr, data}; op 0 = write, op 1 = read and compare.
    localparam int NV = 33;
    localparam logic [28:0] TBL [NV] = '{
        {1'b0, 4'd2, 16'h0022, 8'h27}, {1'b0, 4'd2, 16'h0024, 8'h5A},
        {1'b0, 4'd2, 16'h0022, 8'h27}, {1'b1, 4'd2, 16'h0024, 8'h5A}, // R2
        {1'b1, 4'd3, 16'h0024, 8'hFF},                                 // R3 unarmed read
        {1'b0, 4'd3, 16'h0024, 8'h33}, {1'b0, 4'd3, 16'h0022, 8'h27},
        {1'b1, 4'd3, 16'h0024, 8'h5A},                                 // R3 unarmed write lost
        {1'b0, 4'd5, 16'h0022, 8'h20}, {1'b0, 4'd5, 16'h0024, 8'hFF},
        {1'b0, 4'd5, 16'h0022, 8'h20}, {1'b1, 4'd5, 16'h0024, 8'h7F}, // R5
        {1'b0, 4'd5, 16'h0022, 8'h20}, {1'b0, 4'd5, 16'h0024, 8'h00},
        {1'b0, 4'd5, 16'h0022, 8'h20}, {1'b1, 4'd5, 16'h0024, 8'h40}, // R5
        {1'b0, 4'd4, 16'h0022, 8'h1F}, {1'b0, 4'd4, 16'h0024, 8'h11},
        {1'b0, 4'd4, 16'h0022, 8'h1F}, {1'b1, 4'd4, 16'h0024, 8'hFF}, // R4 below
        {1'b0, 4'd4, 16'h0022, 8'h2C}, {1'b0, 4'd4, 16'h0024, 8'hC3},
        {1'b0, 4'd4, 16'h0022, 8'h2C}, {1'b1, 4'd4, 16'h0024, 8'hC3}, // R4 extra
        {1'b0, 4'd4, 16'h0022, 8'h2D}, {1'b1, 4'd4, 16'h0024, 8'hFF}, // R4 above
        {1'b0, 4'd9, 16'h0022, 8'h23}, {1'b0, 4'd9, 16'h0026, 8'h99},
        {1'b0, 4'd9, 16'h0024, 8'h77}, {1'b0, 4'd9, 16'h0022, 8'h23},
        {1'b1, 4'd9, 16'h0024, 8'h77},                                 // R9
        {1'b1, 4'd8, 16'h0022, 8'h77},                                 // R8 other read holds
        {1'b1, 4'd8, 16'h0030, 8'h77}                                  // R8
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] v0, output logic [7:0] v1);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        v0 = rdata0; v1 = rdata1;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap_in = s; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] exp_default(input logic [7:0] idx, input logic s);
        case (idx)
            8'h20: return 8'h40;
            8'h22, 8'h28, 8'h2A: return 8'h80;
            8'h29, 8'h2B: return 8'h10;
            8'h25: return s ? 8'hF1 : 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v0, v1;
        do_reset(1'b1);
        // R1 reset state at the outputs
        check("R1 rdata", rdata0, 8'hFF);
        check("R1 chg_valid", {7'b0, cv0}, 8'h00);
        for (int i = 8'h20; i <= 8'h2C; i++) begin
            do_wr(16'h0022, 8'(i));
            do_rd(16'h0024, v0, v1);
            check($sformatf("R1 default %h", i), v0, exp_default(8'(i), 1'b1));
        end
        // R6 strap low
        do_reset(1'b0);
        do_wr(16'h0022, 8'h25);
        do_rd(16'h0024, v0, v1);
        check("R6 strap=0", v0, 8'hF0);
        do_reset(1'b1);
        do_wr(16'h0022, 8'h25);
        do_rd(16'h0024, v0, v1);
        check("R6 strap=1", v0, 8'hF1);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][28] == 1'b0) do_wr(TBL[i][23:8], TBL[i][7:0]);
            else begin
                do_rd(TBL[i][23:8], v0, v1);
                check($sformatf("R%0d table step %0d", TBL[i][27:24], i), v0, TBL[i][7:0]);
            end
        end

        // R7 strobe on an accepted write, one cycle wide
        do_wr(16'h0022, 8'h2B);
        @(negedge clk);
        io_addr = 16'h0024; io_wdata = 8'h42; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R7 strobe high", {7'b0, cv0}, 8'h01);
        check("R7 strobe index", cidx0, 8'h2B);
        @(negedge clk);
        check("R7 strobe low", {7'b0, cv0}, 8'h00);
        // R7 discarded write: no strobe
        @(negedge clk);
        io_addr = 16'h0024; io_wdata = 8'h43; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R7 no strobe unarmed", {7'b0, cv0}, 8'h00);
        // R4 variant without the extra register
        do_wr(16'h0022, 8'h2C);
        @(negedge clk);
        io_addr = 16'h0024; io_wdata = 8'h5C; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R4 extra strobe", {7'b0, cv0}, 8'h01);
        check("R4 no extra strobe", {7'b0, cv1}, 8'h00);
        do_wr(16'h0022, 8'h2C);
        do_rd(16'h0024, v0, v1);
        check("R4 extra read", v0, 8'h5C);
        check("R4 no extra read", v1, 8'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule